// File: doc/BRIEF.md
# Counter Bit-Edge Interrupt Generator

This block keeps a free-running binary counter and turns it into a periodic interrupt source. Two counter bit positions are picked at build time. Whenever either of them goes from 0 to 1, the block raises a one-cycle interrupt pulse. In the same clock edge it stores the counter value at which the rise was seen.

Software, or any other reader, fetches the stored value with a read strobe. The value appears on a registered read-data output one cycle after the strobe. Two or more copies can run side by side with different bit pairs, set by parameters alone. For example, one copy can watch bits 16 and 18 and another bits 14 and 16. At a 10 MHz clock, the pair 16/18 gives an interrupt every few milliseconds.

The reset is synchronous and active high. Everything here runs in one clock domain. Carrying the pulse and the read port into a processor's clock domain, and any bus wrapper, belong to the surrounding logic.

Top module: `cbi_irq_gen`

## Requirements
- R1: The counter is `CNT_W` bits wide. It rises by exactly 1 on every clock edge that is not in reset, and it wraps from all ones to zero.
- R2: When the counter holds a value v in which watched bit `BIT_A` or `BIT_B` is 1 and was 0 one cycle earlier, `irq` is 1 in the following cycle only. In every other cycle `irq` is 0, so a pulse is always exactly one cycle wide.
- R3: On the edge that raises `irq`, the capture register takes the value v that produced the rise. This value is one less than the counter value in the cycle where `irq` is high.
- R4: A watched bit falling from 1 to 0 raises no interrupt and leaves the capture register unchanged.
- R5: If both watched bits rise in the same cycle, which happens when `BIT_A` equals `BIT_B`, exactly one single-cycle pulse and one capture result.
- R6: A new capture replaces the stored value even if nobody has read it. A read after several unread captures returns the most recent one.
- R7: When `rdEn` is 1 at a clock edge, `rdData` shows the capture register's value from before that edge, starting in the next cycle. When `rdEn` is 0, `rdData` keeps its value.
- R8: While `rst` is 1 at a clock edge, the counter, the edge-history flops, the capture register, `rdData` and `irq` all become 0. No pulse follows the release of reset until a watched bit rises again from a counter value of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdEn | input | 1 | Read strobe: loads the captured value into rdData |
| rdData | output | CNT_W | Registered copy of the capture register |
| irq | output | 1 | Registered single-cycle interrupt pulse |

## Verification
The assertions assume that `rst` is driven to 1 from time zero and held for at least one edge before normal running. They also assume both watched bit indices lie between 1 and `CNT_W`-1. Under that index constraint, two rises can never fall on consecutive counter values, so the one-cycle-pulse property holds.

The bench drives reset from the first instant and only picks legal bit pairs. It places them low in the counter so that many rises, and a wrap of an 8-bit copy, happen within a short run. The read strobe is drawn at random each cycle, with a directed stretch of no reads followed by a single read, and a reset applied in mid-run.

// File: rtl/cbi_pkg.sv
package cbi_pkg;

  // Strobes handed from the control half to the datapath half each cycle.
  typedef struct packed {
    logic captureEn;  // store the current counter value
    logic readLoad;   // copy the stored value to the read register
  } ctlStrobes_t;

  localparam int WATCH_N = 2;  // number of watched counter bits

endpackage

// File: rtl/cbi_datapath.sv
module cbi_datapath
  import cbi_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BIT_A = 16,
  parameter int BIT_B = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  output logic [WATCH_N-1:0] watchBits,
  output logic [CNT_W-1:0]  rdData
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] capReg;

  // Free-running counter.
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_ONE;
  end

  // Tap the selected bits; index 0 watches BIT_A, index 1 watches BIT_B.
  for (genvar gi = 0; gi < WATCH_N; gi++) begin : g_tap
    localparam int TAP = (gi == 0) ? BIT_A : BIT_B;
    assign watchBits[gi] = cnt[TAP];
  end

  // Capture register: always overwritten by a new event.
  always_ff @(posedge clk) begin
    if (rst)                    capReg <= '0;
    else if (strobes.captureEn) capReg <= cnt;
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst)                   rdData <= '0;
    else if (strobes.readLoad) rdData <= capReg;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) + CNT_ONE)) else $error("count step");  // R1

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
    strobes.captureEn |=> (capReg == cnt - CNT_ONE)) else $error("capture value");  // R3

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.captureEn |=> $stable(capReg)) else $error("capture hold");  // R4

  AST_READ_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobes.readLoad |=> (rdData == $past(capReg))) else $error("read load");  // R7

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.readLoad |=> $stable(rdData)) else $error("read hold");  // R7

endmodule

// File: rtl/cbi_control.sv
module cbi_control
  import cbi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [WATCH_N-1:0] watchBits,
  input  logic               rdEn,
  output ctlStrobes_t        strobes,
  output logic               irq
);

  logic [WATCH_N-1:0] prevBits;
  logic [WATCH_N-1:0] risen;
  logic               anyRise;

  // One-cycle history of each watched bit.
  always_ff @(posedge clk) begin
    if (rst) prevBits <= '0;
    else     prevBits <= watchBits;
  end

  // Only the 0-to-1 direction qualifies; simultaneous rises merge.
  always_comb begin
    risen   = watchBits & ~prevBits;
    anyRise = |risen;
  end

  always_comb begin
    strobes.captureEn = anyRise;
    strobes.readLoad  = rdEn;
  end

  // Registered pulse, free of combinational glitches.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= anyRise;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq) else $error("pulse width");  // R2

  AST_PULSE_NEEDS_HIGH_BIT: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|$past(watchBits))) else $error("pulse source");  // R4

  AST_PULSE_MATCHES_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    strobes.captureEn |=> irq) else $error("pulse vs capture");  // R5

endmodule

// File: rtl/cbi_irq_gen.sv
module cbi_irq_gen
  import cbi_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BIT_A = 16,
  parameter int BIT_B = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdEn,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);

  ctlStrobes_t        strobes;
  logic [WATCH_N-1:0] watchBits;

  cbi_control u_ctl (
    .clk       (clk),
    .rst       (rst),
    .watchBits (watchBits),
    .rdEn      (rdEn),
    .strobes   (strobes),
    .irq       (irq)
  );

  cbi_datapath #(
    .CNT_W (CNT_W),
    .BIT_A (BIT_A),
    .BIT_B (BIT_B)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .watchBits (watchBits),
    .rdData    (rdData)
  );

endmodule

// File: tb/sim_cbi_irq_gen.sv
module sim_cbi_irq_gen;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [2:0]  rdEn = '0;
  logic [31:0] rd0, rd1;
  logic [7:0]  rd2;
  logic [2:0]  irq;

  int errors = 0;
  int checks = 0;

  // u0 mirrors a 16/18 pair, u1 a 14/16 pair, u2 an 8-bit copy with equal bits.
  cbi_irq_gen #(.CNT_W(32), .BIT_A(4), .BIT_B(6)) u0 (
    .clk(clk), .rst(rst), .rdEn(rdEn[0]), .rdData(rd0), .irq(irq[0]));
  cbi_irq_gen #(.CNT_W(32), .BIT_A(2), .BIT_B(4)) u1 (
    .clk(clk), .rst(rst), .rdEn(rdEn[1]), .rdData(rd1), .irq(irq[1]));
  cbi_irq_gen #(.CNT_W(8), .BIT_A(3), .BIT_B(3)) u2 (
    .clk(clk), .rst(rst), .rdEn(rdEn[2]), .rdData(rd2), .irq(irq[2]));

  logic [31:0] mCnt [3];
  logic [31:0] mCap [3];
  logic [31:0] mRd  [3];
  logic [2:0]  mIrq;
  logic [31:0] lastCap0;

  function automatic int widthOf(int i);
    return (i == 2) ? 8 : 32;
  endfunction
  function automatic int bitAOf(int i);
    return (i == 0) ? 4 : ((i == 1) ? 2 : 3);
  endfunction
  function automatic int bitBOf(int i);
    return (i == 0) ? 6 : ((i == 1) ? 4 : 3);
  endfunction
  function automatic logic [31:0] maskOf(int i);
    return (widthOf(i) == 32) ? 32'hFFFF_FFFF : ((32'd1 << widthOf(i)) - 32'd1);
  endfunction
  // True when bit b is 1 at value v and was 0 at the previous count.
  function automatic logic rose(logic [31:0] v, int b, logic [31:0] mask);
    logic [31:0] pv;
    pv = (v - 32'd1) & mask;
    return (v != 0) && v[b] && !pv[b];
  endfunction
  function automatic logic expIrq(int i, logic [31:0] v);
    return rose(v, bitAOf(i), maskOf(i)) | rose(v, bitBOf(i), maskOf(i));
  endfunction
  function automatic logic [31:0] rdOf(int i);
    return (i == 0) ? rd0 : ((i == 1) ? rd1 : {24'd0, rd2});
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance one clock, updating the model, then check all outputs.
  task automatic step();
    for (int i = 0; i < 3; i++) begin
      if (rst) begin
        mIrq[i] = 1'b0;
        mCnt[i] = '0;
        mCap[i] = '0;
        mRd[i]  = '0;
      end else begin
        mIrq[i] = expIrq(i, mCnt[i]);
        if (rdEn[i]) mRd[i] = mCap[i];
        if (mIrq[i]) mCap[i] = mCnt[i];
        mCnt[i] = (mCnt[i] + 32'd1) & maskOf(i);
      end
    end
    if (mIrq[0]) lastCap0 = mCap[0];
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check((i == 2) ? "R2/R4/R5" : "R2/R4", $sformatf("irq u%0d", i),
            {31'd0, irq[i]}, {31'd0, mIrq[i]});
      check("R1/R3/R7", $sformatf("rdData u%0d", i), rdOf(i), mRd[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    lastCap0 = '0;
    @(negedge clk);
    // R8: reset state
    rst = 1'b1;
    repeat (4) step();
    for (int i = 0; i < 3; i++) check("R8", "rdData in reset", rdOf(i), 32'd0);
    check("R8", "irq in reset", {29'd0, irq}, 32'd0);
    rst = 1'b0;
    // Read right after reset returns the cleared capture register (R8).
    rdEn = 3'b111;
    step();
    rdEn = '0;
    step();
    for (int i = 0; i < 3; i++) check("R8", "capture after reset", rdOf(i), 32'd0);

    // Random read strobes across many rises, including the 8-bit wrap (R1).
    for (int n = 0; n < 400; n++) begin
      rdEn = {($urandom % 10) < 3, ($urandom % 10) < 3, ($urandom % 10) < 3};
      step();
    end

    // R6: several unread captures, then one read returns the latest.
    rdEn = '0;
    repeat (100) step();
    rdEn = 3'b001;
    step();
    rdEn = '0;
    step();
    check("R6", "latest capture u0", rd0, lastCap0);

    // Mid-run reset, then random running again (R8).
    rst = 1'b1;
    repeat (2) step();
    check("R8", "irq mid-run reset", {29'd0, irq}, 32'd0);
    rst = 1'b0;
    for (int n = 0; n < 300; n++) begin
      rdEn = {($urandom % 10) < 4, ($urandom % 10) < 4, ($urandom % 10) < 4};
      step();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule